// File: doc/BRIEF.md
# Quadrature Encoder Input Decoder

This block sits between two encoder phase pins and an up/down counter. It samples both phases on the system clock and turns their motion into count pulses. Each pulse is a one-cycle strobe, and a direction bit travels with it. The counter adds one on each strobe when the direction bit is 1 and subtracts one when it is 0.

Two operating modes are selected by a static input. In quadrature mode each phase is synchronized and then debounced: a new level is accepted only after it has held for three consecutive synchronized samples. The accepted levels are decoded into count events at x1, x2 or x4 resolution. If both phases change in the same accepted sample, the transition cannot be decoded, so the block raises a sticky error flag instead of counting. In bypass mode the debouncer and the decoder are skipped: phase A acts as a plain count clock and phase B is a direction level. An enable input gates both phases, so when it is low nothing counts.

Top module: `quad_phase_decoder`

## Requirements
- R1: In quadrature mode a change on either phase is accepted only after the synchronized level has held for 3 consecutive samples. A level applied just before a clock edge produces its strobe after the 5th rising edge. A pulse lasting 2 cycles produces no strobe.
- R2: In quadrature mode, the sequence (A,B) = 00, 10, 11, 01, 00 is upward motion and the reverse sequence is downward motion. After any accepted single-phase change, cnt_dir_o shows the direction of that change (1 = up, 0 = down).
- R3: res_sel_i selects the quadrature resolution. Value 0 (x1) strobes only on a rising edge of A. Value 1 (x2) strobes on both edges of A. Values 2 and 3 (x4) strobe on every edge of A or B.
- R4: In quadrature mode, when A and B change in the same accepted sample, noise_err_o is set and no strobe is produced.
- R5: noise_err_o stays set until noise_clr_i is high on a clock edge. When a set and a clear occur on the same edge, the clear wins.
- R6: In bypass mode (quad_mode_i = 0) there is no debouncing. A strobe follows each rising edge of the synchronized A, 3 edges after the change, and res_sel_i has no effect.
- R7: In bypass mode cnt_dir_o follows the synchronized B level: 1 means up and 0 means down.
- R8: While ab_en_i is low, no strobe is produced, noise_err_o is not set and cnt_dir_o holds its value. Raising ab_en_i again while the phases are steady produces no strobe.
- R9: After reset, cnt_strobe_o, cnt_dir_o and noise_err_o are all 0.
- R10: cnt_strobe_o is a single-cycle pulse per count event. In bypass mode it is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pha_i | input | 1 | Encoder phase A (count clock in bypass mode) |
| phb_i | input | 1 | Encoder phase B (direction level in bypass mode) |
| ab_en_i | input | 1 | Enable for both phase inputs |
| quad_mode_i | input | 1 | 1 = quadrature decode, 0 = bypass |
| res_sel_i | input | 2 | Quadrature resolution: 0 = x1, 1 = x2, 2 or 3 = x4 |
| noise_clr_i | input | 1 | Clears the noise flag |
| cnt_strobe_o | output | 1 | One-cycle count pulse |
| cnt_dir_o | output | 1 | Count direction, 1 = up |
| noise_err_o | output | 1 | Sticky flag for an undecodable transition |

## Verification
The debounced phase levels are the decoder's only memory, so a fault in them shows up in the next transition. That transition then produces the wrong number of strobes, the wrong direction, or a false noise flag, within about ten cycles. For this reason the bench walks every transition between the four phase states in each resolution and in bypass mode, and compares each result against a table of expected strobe counts. Latency is measured to the exact edge, and short pulses are applied, so that a debounce stage that is too short or too long is caught at the first change it handles.

// File: rtl/quad_phase_decoder.sv
module quad_phase_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pha_i,
  input  logic       phb_i,
  input  logic       ab_en_i,
  input  logic       quad_mode_i,
  input  logic [1:0] res_sel_i,
  input  logic       noise_clr_i,
  output logic       cnt_strobe_o,
  output logic       cnt_dir_o,
  output logic       noise_err_o
);
  localparam int HW = FILT_LEN - 1;

  logic [SYNC_STAGES-1:0] a_sync, b_sync;
  logic [HW-1:0]          a_hist, b_hist;
  logic                   a_f, b_f, a_q;
  logic                   a_s, b_s;
  logic                   a_nx, b_nx;
  logic                   edge_a, edge_b, bad, up, q_hit, nq_hit;

  assign a_s = a_sync[SYNC_STAGES-1];
  assign b_s = b_sync[SYNC_STAGES-1];

  // accept a level once it has filled the whole history window
  assign a_nx = (&{a_hist, a_s}) ? 1'b1 : (~|{a_hist, a_s}) ? 1'b0 : a_f;
  assign b_nx = (&{b_hist, b_s}) ? 1'b1 : (~|{b_hist, b_s}) ? 1'b0 : b_f;

  assign edge_a = (a_nx ^ a_f) & ~(b_nx ^ b_f);
  assign edge_b = (b_nx ^ b_f) & ~(a_nx ^ a_f);
  assign bad    = (a_nx ^ a_f) & (b_nx ^ b_f);
  assign up     = edge_a ? (a_nx ^ b_f) : ~(b_nx ^ a_f);
  assign nq_hit = a_s & ~a_q;

  always_comb begin
    case (res_sel_i)
      2'd0:    q_hit = edge_a & a_nx;
      2'd1:    q_hit = edge_a;
      default: q_hit = edge_a | edge_b;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sync <= '0;
      b_sync <= '0;
      a_hist <= '0;
      b_hist <= '0;
      a_f    <= 1'b0;
      b_f    <= 1'b0;
      a_q    <= 1'b0;
    end else begin
      a_sync <= {a_sync[SYNC_STAGES-2:0], pha_i};
      b_sync <= {b_sync[SYNC_STAGES-2:0], phb_i};
      a_hist <= {a_hist[HW-2:0], a_s};
      b_hist <= {b_hist[HW-2:0], b_s};
      a_f    <= a_nx;
      b_f    <= b_nx;
      a_q    <= a_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_strobe_o <= 1'b0;
      cnt_dir_o    <= 1'b0;
      noise_err_o  <= 1'b0;
    end else begin
      cnt_strobe_o <= ab_en_i & (quad_mode_i ? q_hit : nq_hit);
      if (ab_en_i) begin
        if (!quad_mode_i)           cnt_dir_o <= b_s;
        else if (edge_a || edge_b)  cnt_dir_o <= up;
      end
      if (noise_clr_i)                          noise_err_o <= 1'b0;
      else if (ab_en_i && quad_mode_i && bad)   noise_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/quad_phase_decoder_chk.sv
module quad_phase_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ab_en_i,
  input logic       quad_mode_i,
  input logic       noise_clr_i,
  input logic       cnt_strobe_o,
  input logic       cnt_dir_o,
  input logic       noise_err_o
);
  p_gate_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_en_i |=> !cnt_strobe_o);

  p_gate_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_en_i |=> $stable(cnt_dir_o));

  p_noise_quad_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!quad_mode_i || !ab_en_i) && !noise_err_o |=> !noise_err_o);

  p_noise_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    noise_clr_i |=> !noise_err_o);

  p_noise_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    noise_err_o && !noise_clr_i |=> noise_err_o);

  p_bypass_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_strobe_o && !quad_mode_i && $past(!quad_mode_i) |=> !cnt_strobe_o);
endmodule

bind quad_phase_decoder quad_phase_decoder_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ab_en_i      (ab_en_i),
  .quad_mode_i  (quad_mode_i),
  .noise_clr_i  (noise_clr_i),
  .cnt_strobe_o (cnt_strobe_o),
  .cnt_dir_o    (cnt_dir_o),
  .noise_err_o  (noise_err_o)
);

// File: tb/quad_phase_decoder_tb_top.sv
module quad_phase_decoder_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pha_i = 1'b0, phb_i = 1'b0, ab_en_i = 1'b1, quad_mode_i = 1'b1;
  logic [1:0] res_sel_i = 2'd2;
  logic       noise_clr_i = 1'b0;
  logic       cnt_strobe_o, cnt_dir_o, noise_err_o;

  int n_chk = 0, n_fail = 0, n_strobe = 0;

  always #(CLK_P/2) clk = ~clk;

  quad_phase_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .pha_i(pha_i), .phb_i(phb_i), .ab_en_i(ab_en_i),
    .quad_mode_i(quad_mode_i), .res_sel_i(res_sel_i), .noise_clr_i(noise_clr_i),
    .cnt_strobe_o(cnt_strobe_o), .cnt_dir_o(cnt_dir_o), .noise_err_o(noise_err_o)
  );

  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (rst_n && cnt_strobe_o) n_strobe++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_noise();
    noise_clr_i = 1'b1;
    @(negedge clk);
    noise_clr_i = 1'b0;
    settle(1);
  endtask

  task automatic put(input logic [1:0] ab);
    pha_i = ab[1];
    phb_i = ab[0];
    settle(10);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    chk(cnt_strobe_o == 0, "R9 strobe after reset", cnt_strobe_o, 0);
    chk(cnt_dir_o == 0, "R9 dir after reset", cnt_dir_o, 0);
    chk(noise_err_o == 0, "R9 noise after reset", noise_err_o, 0);

    // exhaustive transition sweep: m=0..2 quadrature x1/x2/x4, m=3 bypass
    for (int m = 0; m < 4; m++) begin
      quad_mode_i = (m < 3);
      res_sel_i   = (m < 3) ? 2'(m) : 2'd2;
      for (int fr = 0; fr < 4; fr++) begin
        for (int to = 0; to < 4; to++) begin
          logic oa, ob, na, nb, da, db;
          int e_cnt, e_dir, e_noise;
          bit dir_known;
          put(2'(fr));
          clear_noise();
          n_strobe = 0;
          oa = fr[1]; ob = fr[0]; na = to[1]; nb = to[0];
          da = oa ^ na; db = ob ^ nb;
          e_cnt = 0; e_dir = 0; e_noise = 0; dir_known = 0;
          if (m == 3) begin
            e_cnt = (!oa && na) ? 1 : 0;
            e_dir = nb; dir_known = 1;
          end else if (da && db) begin
            e_noise = 1;
          end else if (da) begin
            e_dir = na ^ ob; dir_known = 1;
            e_cnt = (m == 0) ? int'(na) : 1;
          end else if (db) begin
            e_dir = !(nb ^ oa); dir_known = 1;
            e_cnt = (m == 2) ? 1 : 0;
          end
          put(2'(to));
          if (m == 3) chk(n_strobe == e_cnt, "R6 bypass strobe count", n_strobe, e_cnt);
          else if (da && db) chk(n_strobe == 0, "R4 illegal step counts nothing", n_strobe, 0);
          else chk(n_strobe == e_cnt, "R3 resolution strobe count", n_strobe, e_cnt);
          if (dir_known) begin
            if (m == 3) chk(cnt_dir_o == e_dir, "R7 bypass dir follows B", cnt_dir_o, e_dir);
            else chk(cnt_dir_o == e_dir, "R2 quadrature direction", cnt_dir_o, e_dir);
          end
          if (e_noise) chk(noise_err_o == 1, "R4 noise flag set", noise_err_o, 1);
          else chk(noise_err_o == 0, "R4 noise flag quiet", noise_err_o, 0);
        end
      end
    end

    // sticky flag and clear
    quad_mode_i = 1; res_sel_i = 2'd2;
    put(2'b00); clear_noise();
    put(2'b11);
    settle(20);
    chk(noise_err_o == 1, "R5 noise stays set", noise_err_o, 1);
    clear_noise();
    chk(noise_err_o == 0, "R5 noise cleared", noise_err_o, 0);

    // latency and pulse filtering, quadrature
    put(2'b00);
    begin
      int first = 0;
      pha_i = 1;
      for (int k = 1; k <= 8; k++) begin
        @(negedge clk);
        if (cnt_strobe_o && first == 0) first = k;
      end
      chk(first == 5, "R1 quadrature latency", first, 5);
    end
    put(2'b00);
    n_strobe = 0;
    pha_i = 1; settle(2); pha_i = 0; settle(10);
    chk(n_strobe == 0, "R1 short pulse ignored", n_strobe, 0);

    // latency and no filtering, bypass
    quad_mode_i = 0;
    put(2'b00);
    begin
      int first = 0;
      pha_i = 1;
      for (int k = 1; k <= 8; k++) begin
        @(negedge clk);
        if (cnt_strobe_o && first == 0) first = k;
      end
      chk(first == 3, "R6 bypass latency", first, 3);
    end
    put(2'b00);
    n_strobe = 0;
    pha_i = 1; settle(2); pha_i = 0; settle(10);
    chk(n_strobe == 1, "R6 bypass short pulse counts", n_strobe, 1);
    n_strobe = 0;
    for (int i = 0; i < 5; i++) begin
      pha_i = 1; settle(1); pha_i = 0; settle(1);
    end
    settle(6);
    chk(n_strobe == 5, "R10 one strobe per bypass edge", n_strobe, 5);

    // enable gating
    quad_mode_i = 1; res_sel_i = 2'd2;
    put(2'b00); clear_noise();
    put(2'b10);
    chk(cnt_dir_o == 1, "R2 up step sets dir", cnt_dir_o, 1);
    ab_en_i = 0;
    n_strobe = 0;
    put(2'b11);
    chk(n_strobe == 0, "R8 disabled no strobe", n_strobe, 0);
    put(2'b00);
    chk(noise_err_o == 0, "R8 disabled no noise", noise_err_o, 0);
    put(2'b01);
    chk(cnt_dir_o == 1, "R8 disabled dir held", cnt_dir_o, 1);
    quad_mode_i = 0;
    put(2'b11);
    chk(n_strobe == 0, "R8 disabled bypass no strobe", n_strobe, 0);
    put(2'b01);
    quad_mode_i = 1;
    settle(4);
    ab_en_i = 1;
    settle(10);
    chk(n_strobe == 0, "R8 re-enable no strobe", n_strobe, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule